// File: doc/BRIEF.md
# Shared-Pool Multi-Thread Register Renamer

This block turns architectural register numbers into physical register tags for several hardware threads. Every thread owns a private mapping table, while all threads draw destination tags from a single pool of physical registers. A freed tag can next be handed to any thread. Because each thread reads only its own table, and dependences travel downstream purely as physical tags, two threads never see a false dependence on each other.

Each cycle the front end may present one group of up to `W` decoded instructions, all from the thread named by `in_tid`. For each valid slot the block returns the physical tags of both sources. For each slot that writes a register, it also returns a freshly allocated destination tag and the tag that destination held before. That previous tag is carried to commit and handed back on a release port, which puts it back in the pool. If the pool cannot cover every destination in the group, the whole group is refused that cycle.

A small controller with three states sequences the result register. `ST_IDLE` means no result is presented. `ST_RESULT` means a renamed group is on the outputs. `ST_STALLED` means the last offered group was refused. From any state:
- an accepted group moves the controller to `ST_RESULT`;
- a refused group moves it to `ST_STALLED`;
- a cycle with no group moves it to `ST_IDLE`.

Top module: `rn_rename_table`

## Requirements
- R1: After reset, architectural register i of thread t maps to physical tag t*A+i (A architectural registers per thread). The pool holds every tag from T*A to P-1.
- R2: Each thread's table is chosen by `in_tid`. Renaming a group of one thread leaves the source tags read by any other thread unchanged.
- R3: New destination tags are the lowest-numbered free tags. They are handed out in ascending order to the destination-writing slots in slot order, and are all distinct.
- R4: When a source of slot k names the destination of an earlier slot j<k in the same group, it receives the newest such earlier slot's new tag. Otherwise it receives the table entry.
- R5: `out_old_tag` of a destination-writing slot is the mapping that destination had just before that slot. This includes a new tag given to the same register by an earlier slot of the group.
- R6: `in_stall` is high, in the same cycle, exactly when `in_valid` is high and the number of valid slots with `in_dst_en` set exceeds the free tag count. A stalled group changes no table entry and takes no tag, and `out_valid` is low in the following cycle.
- R7: A tag on a valid commit slot (`cm_valid[c]`, tag in bits `cm_tag[c*TW +: TW]`) joins the pool at the clock edge. It is not counted as free and cannot be allocated in that same cycle.
- R8: An accepted group appears on the outputs one clock later with `out_valid` high. Slots without `in_dst_en` consume no tag. `out_valid` is low after reset and after any cycle without an accepted group.
- R9: A tag released by a commit of one thread may be allocated to a different thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group is offered this cycle |
| in_tid | input | TIDW | Thread of the offered group |
| in_slot_vld | input | W | Slot holds an instruction |
| in_dst_en | input | W | Slot writes a destination register |
| in_dst_arch | input | W*AW | Destination register per slot |
| in_src_a | input | W*AW | First source register per slot |
| in_src_b | input | W*AW | Second source register per slot |
| in_stall | output | 1 | Group refused this cycle (pool too small) |
| cm_valid | input | C | Commit release slot valid |
| cm_tag | input | C*TW | Tag returned to the pool per commit slot |
| out_valid | output | 1 | Renamed group present |
| out_tid | output | TIDW | Thread of the renamed group |
| out_slot_vld | output | W | Slot valid of the renamed group |
| out_dst_en | output | W | Slot wrote a destination |
| out_src_a_tag | output | W*TW | Physical tag of first source |
| out_src_b_tag | output | W*TW | Physical tag of second source |
| out_dst_tag | output | W*TW | Newly allocated destination tag |
| out_old_tag | output | W*TW | Previous mapping of the destination |

## Verification
Allocation for a new group and release from commit can fall in the same cycle, and both act on the one shared pool. The bench provokes this in two ways. First, it drains the pool and then offers a group while commit returns tags in that very cycle. The group must still stall, and the returned tags must be handed out from the next cycle, possibly to the other thread. Second, it offers a group at the same time as commit releases tags that are too few to cover it. The expected stall flag and every expected tag come from a reference table and a free-tag model kept in the bench. In that model, allocation is judged against the pool contents before the releases of the cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESULT  = 2'd1,
        ST_STALLED = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int P    = 32,
    parameter int W    = 4,
    parameter int C    = 2,
    parameter int RESV = 16,
    parameter int TW   = 5,
    parameter int CW   = 6,
    parameter int NW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_go,
    input  logic [NW-1:0]   alloc_num,
    input  logic [C-1:0]    rel_vld,
    input  logic [C*TW-1:0] rel_tags,
    output logic [W*TW-1:0] pick_tags,
    output logic [CW-1:0]   free_cnt
);
    logic [P-1:0] free_q;
    logic [P-1:0] free_d;
    logic [P-1:0] alloc_mask;
    logic [P-1:0] rel_mask;

    // successive lowest-free picks, each excluding the earlier ones
    always_comb begin
        logic [P-1:0] avail;
        logic         found;
        avail     = free_q;
        pick_tags = '0;
        for (int k = 0; k < W; k++) begin
            found = 1'b0;
            for (int i = 0; i < P; i++) begin
                if (!found && avail[i]) begin
                    pick_tags[k*TW +: TW] = TW'(i);
                    found = 1'b1;
                end
            end
            if (found) avail[pick_tags[k*TW +: TW]] = 1'b0;
        end
    end

    always_comb begin
        alloc_mask = '0;
        for (int k = 0; k < W; k++) begin
            if (alloc_go && (NW'(k) < alloc_num))
                alloc_mask[pick_tags[k*TW +: TW]] = 1'b1;
        end
    end

    always_comb begin
        rel_mask = '0;
        for (int c = 0; c < C; c++) begin
            if (rel_vld[c]) rel_mask[rel_tags[c*TW +: TW]] = 1'b1;
        end
    end

    assign free_d   = (free_q & ~alloc_mask) | rel_mask;
    assign free_cnt = CW'($countones(free_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < P; i++) free_q[i] <= (i >= RESV);
        end else begin
            free_q <= free_d;
        end
    end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int T    = 2,
    parameter int A    = 8,
    parameter int W    = 4,
    parameter int TW   = 5,
    parameter int AW   = 3,
    parameter int TIDW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TIDW-1:0] rd_tid,
    input  logic [W*AW-1:0] rd_a,
    input  logic [W*AW-1:0] rd_b,
    input  logic [W*AW-1:0] rd_d,
    output logic [W*TW-1:0] tag_a,
    output logic [W*TW-1:0] tag_b,
    output logic [W*TW-1:0] tag_d,
    input  logic            wr_go,
    input  logic [W-1:0]    wr_en,
    input  logic [W*AW-1:0] wr_arch,
    input  logic [W*TW-1:0] wr_tag
);
    logic [TW-1:0] maps_q [T][A];

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_rd
            assign tag_a[g*TW +: TW] = maps_q[rd_tid][rd_a[g*AW +: AW]];
            assign tag_b[g*TW +: TW] = maps_q[rd_tid][rd_b[g*AW +: AW]];
            assign tag_d[g*TW +: TW] = maps_q[rd_tid][rd_d[g*AW +: AW]];
        end
    endgenerate

    // later slots in the group overwrite earlier ones for the same register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < T; t++)
                for (int i = 0; i < A; i++)
                    maps_q[t][i] <= TW'(t*A + i);
        end else if (wr_go) begin
            for (int k = 0; k < W; k++)
                if (wr_en[k])
                    maps_q[rd_tid][wr_arch[k*AW +: AW]] <= wr_tag[k*TW +: TW];
        end
    end
endmodule

// File: rtl/rn_group_xlate.sv
module rn_group_xlate #(
    parameter int W  = 4,
    parameter int TW = 5,
    parameter int AW = 3,
    parameter int NW = 3
) (
    input  logic [W-1:0]    slot_vld,
    input  logic [W-1:0]    dst_en,
    input  logic [W*AW-1:0] dst_arch,
    input  logic [W*AW-1:0] src_a,
    input  logic [W*AW-1:0] src_b,
    input  logic [W*TW-1:0] tbl_a,
    input  logic [W*TW-1:0] tbl_b,
    input  logic [W*TW-1:0] tbl_d,
    input  logic [W*TW-1:0] picks,
    output logic [W-1:0]    wr_en,
    output logic [W*TW-1:0] res_a,
    output logic [W*TW-1:0] res_b,
    output logic [W*TW-1:0] res_new,
    output logic [W*TW-1:0] res_old,
    output logic [NW-1:0]   need
);
    assign wr_en = slot_vld & dst_en;

    // rank of each writing slot among writing slots picks its tag
    always_comb begin
        logic [NW-1:0] rank;
        rank    = '0;
        res_new = '0;
        for (int k = 0; k < W; k++) begin
            if (wr_en[k]) begin
                res_new[k*TW +: TW] = picks[int'(rank)*TW +: TW];
                rank = rank + 1'b1;
            end
        end
        need = rank;
    end

    // in-group forwarding: ascending scan so the newest earlier writer wins
    always_comb begin
        res_a   = tbl_a;
        res_b   = tbl_b;
        res_old = tbl_d;
        for (int k = 1; k < W; k++) begin
            for (int j = 0; j < k; j++) begin
                if (wr_en[j]) begin
                    if (dst_arch[j*AW +: AW] == src_a[k*AW +: AW])
                        res_a[k*TW +: TW] = res_new[j*TW +: TW];
                    if (dst_arch[j*AW +: AW] == src_b[k*AW +: AW])
                        res_b[k*TW +: TW] = res_new[j*TW +: TW];
                    if (dst_arch[j*AW +: AW] == dst_arch[k*AW +: AW])
                        res_old[k*TW +: TW] = res_new[j*TW +: TW];
                end
            end
        end
    end
endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl #(
    parameter int CW = 6,
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NW-1:0] need,
    input  logic [CW-1:0] free_cnt,
    output logic          stall,
    output logic          accept,
    output logic          res_valid
);
    import rn_pkg::*;

    rn_state_e state_q;
    rn_state_e state_d;
    logic      short_pool;

    assign short_pool = CW'(need) > free_cnt;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_STALLED: begin
                if (in_valid && !short_pool)     state_d = ST_RESULT;
                else if (in_valid && short_pool) state_d = ST_STALLED;
                else                             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        stall     = in_valid && short_pool;
        accept    = in_valid && !short_pool;
        res_valid = (state_q == ST_RESULT);
    end
endmodule

// File: rtl/rn_rename_table.sv
module rn_rename_table #(
    parameter int T = 2,
    parameter int A = 8,
    parameter int P = 32,
    parameter int W = 4,
    parameter int C = 2,
    localparam int TW   = $clog2(P),
    localparam int AW   = $clog2(A),
    localparam int TIDW = (T > 1) ? $clog2(T) : 1,
    localparam int CW   = $clog2(P + 1),
    localparam int NW   = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [TIDW-1:0] in_tid,
    input  logic [W-1:0]    in_slot_vld,
    input  logic [W-1:0]    in_dst_en,
    input  logic [W*AW-1:0] in_dst_arch,
    input  logic [W*AW-1:0] in_src_a,
    input  logic [W*AW-1:0] in_src_b,
    output logic            in_stall,
    input  logic [C-1:0]    cm_valid,
    input  logic [C*TW-1:0] cm_tag,
    output logic            out_valid,
    output logic [TIDW-1:0] out_tid,
    output logic [W-1:0]    out_slot_vld,
    output logic [W-1:0]    out_dst_en,
    output logic [W*TW-1:0] out_src_a_tag,
    output logic [W*TW-1:0] out_src_b_tag,
    output logic [W*TW-1:0] out_dst_tag,
    output logic [W*TW-1:0] out_old_tag
);
    logic [W*TW-1:0] tbl_a, tbl_b, tbl_d, picks;
    logic [W*TW-1:0] res_a, res_b, res_new, res_old;
    logic [W-1:0]    wr_en;
    logic [NW-1:0]   need;
    logic [CW-1:0]   free_cnt;
    logic            accept;

    rn_free_pool #(.P(P), .W(W), .C(C), .RESV(T*A), .TW(TW), .CW(CW), .NW(NW)) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc_go(accept), .alloc_num(need),
        .rel_vld(cm_valid), .rel_tags(cm_tag), .pick_tags(picks), .free_cnt(free_cnt)
    );

    rn_map_table #(.T(T), .A(A), .W(W), .TW(TW), .AW(AW), .TIDW(TIDW)) u_map (
        .clk(clk), .rst_n(rst_n), .rd_tid(in_tid),
        .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst_arch),
        .tag_a(tbl_a), .tag_b(tbl_b), .tag_d(tbl_d),
        .wr_go(accept), .wr_en(wr_en), .wr_arch(in_dst_arch), .wr_tag(res_new)
    );

    rn_group_xlate #(.W(W), .TW(TW), .AW(AW), .NW(NW)) u_xlate (
        .slot_vld(in_slot_vld), .dst_en(in_dst_en), .dst_arch(in_dst_arch),
        .src_a(in_src_a), .src_b(in_src_b),
        .tbl_a(tbl_a), .tbl_b(tbl_b), .tbl_d(tbl_d), .picks(picks),
        .wr_en(wr_en), .res_a(res_a), .res_b(res_b),
        .res_new(res_new), .res_old(res_old), .need(need)
    );

    rn_ctrl #(.CW(CW), .NW(NW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .need(need),
        .free_cnt(free_cnt), .stall(in_stall), .accept(accept), .res_valid(out_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tid       <= '0;
            out_slot_vld  <= '0;
            out_dst_en    <= '0;
            out_src_a_tag <= '0;
            out_src_b_tag <= '0;
            out_dst_tag   <= '0;
            out_old_tag   <= '0;
        end else if (accept) begin
            out_tid       <= in_tid;
            out_slot_vld  <= in_slot_vld;
            out_dst_en    <= wr_en;
            out_src_a_tag <= res_a;
            out_src_b_tag <= res_b;
            out_dst_tag   <= res_new;
            out_old_tag   <= res_old;
        end
    end
endmodule

// File: rtl/rn_rename_table_chk.sv
module rn_rename_table_chk #(
    parameter int W  = 4,
    parameter int TW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_stall,
    input logic            out_valid,
    input logic [W-1:0]    out_dst_en,
    input logic [W*TW-1:0] out_dst_tag,
    input logic [W*TW-1:0] out_old_tag
);
    logic dup_tag;
    logic self_old;

    always_comb begin
        dup_tag  = 1'b0;
        self_old = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (out_dst_en[k] && out_dst_tag[k*TW +: TW] == out_old_tag[k*TW +: TW])
                self_old = 1'b1;
            for (int j = 0; j < k; j++)
                if (out_dst_en[k] && out_dst_en[j] &&
                    out_dst_tag[k*TW +: TW] == out_dst_tag[j*TW +: TW])
                    dup_tag = 1'b1;
        end
    end

    AST_STALL_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> in_valid);                                   // R6
    AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |=> !out_valid);                                 // R6
    AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_stall) |=> out_valid);                   // R8
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                // R8
    AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !dup_tag);                                  // R3
    AST_NEW_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !self_old);                                 // R5
endmodule

bind rn_rename_table rn_rename_table_chk #(.W(W), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stall(in_stall),
    .out_valid(out_valid), .out_dst_en(out_dst_en),
    .out_dst_tag(out_dst_tag), .out_old_tag(out_old_tag)
);

// File: tb/rn_rename_table_bench.sv
module rn_rename_table_bench;
    localparam int T = 2, A = 8, P = 32, W = 4, C = 2;
    localparam int TW = 5, AW = 3;

    typedef struct packed {
        logic            valid;
        logic            tid;
        logic [W-1:0]    vld;
        logic [W-1:0]    den;
        logic [W*TW-1:0] sa;
        logic [W*TW-1:0] sb;
        logic [W*TW-1:0] dt;
        logic [W*TW-1:0] ot;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_tid = 1'b0;
    logic [W-1:0] in_slot_vld = '0, in_dst_en = '0;
    logic [W*AW-1:0] in_dst_arch = '0, in_src_a = '0, in_src_b = '0;
    logic in_stall;
    logic [C-1:0] cm_valid = '0;
    logic [C*TW-1:0] cm_tag = '0;
    logic out_valid, out_tid;
    logic [W-1:0] out_slot_vld, out_dst_en;
    logic [W*TW-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int ref_map [T][A];
    bit ref_free [P];
    item_t q_exp [$];
    string q_req [$];

    always #2.5 clk = ~clk;

    rn_rename_table #(.T(T), .A(A), .P(P), .W(W), .C(C)) u_rn_rename_table (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
        .in_slot_vld(in_slot_vld), .in_dst_en(in_dst_en), .in_dst_arch(in_dst_arch),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_stall(in_stall),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .out_valid(out_valid), .out_tid(out_tid),
        .out_slot_vld(out_slot_vld), .out_dst_en(out_dst_en),
        .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
        .out_dst_tag(out_dst_tag), .out_old_tag(out_old_tag)
    );

    function automatic logic [W*AW-1:0] pk(int a0, int a1, int a2, int a3);
        return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
    endfunction

    function automatic logic [C*TW-1:0] pc(int t0, int t1);
        return {TW'(t1), TW'(t0)};
    endfunction

    // drive one cycle; model computes stall and expected result
    task automatic drive(input bit gv, input int tid, input logic [W-1:0] v,
                         input logic [W-1:0] de, input logic [W*AW-1:0] d,
                         input logic [W*AW-1:0] sa, input logic [W*AW-1:0] sb,
                         input logic [C-1:0] cv, input logic [C*TW-1:0] ct,
                         input string req);
        item_t e;
        int need, nfree, tmap [A];
        bit avail [P];
        bit exp_stall;
        @(negedge clk);
        in_valid = gv; in_tid = tid[0]; in_slot_vld = v; in_dst_en = de;
        in_dst_arch = d; in_src_a = sa; in_src_b = sb; cm_valid = cv; cm_tag = ct;
        need = 0; nfree = 0;
        for (int k = 0; k < W; k++) if (v[k] && de[k]) need++;
        for (int i = 0; i < P; i++) if (ref_free[i]) nfree++;
        exp_stall = gv && (need > nfree);
        e = '0;
        if (gv && !exp_stall) begin
            e.valid = 1; e.tid = tid[0]; e.vld = v; e.den = v & de;
            for (int i = 0; i < A; i++) tmap[i] = ref_map[tid][i];
            for (int i = 0; i < P; i++) avail[i] = ref_free[i];
            for (int k = 0; k < W; k++) begin
                if (v[k]) begin
                    e.sa[k*TW +: TW] = TW'(tmap[sa[k*AW +: AW]]);
                    e.sb[k*TW +: TW] = TW'(tmap[sb[k*AW +: AW]]);
                    if (de[k]) begin
                        int nt = -1;
                        for (int i = 0; i < P; i++) if (nt < 0 && avail[i]) nt = i;
                        avail[nt] = 0;
                        e.ot[k*TW +: TW] = TW'(tmap[d[k*AW +: AW]]);
                        e.dt[k*TW +: TW] = TW'(nt);
                        tmap[d[k*AW +: AW]] = nt;
                    end
                end
            end
            for (int i = 0; i < A; i++) ref_map[tid][i] = tmap[i];
            for (int i = 0; i < P; i++) ref_free[i] = avail[i];
        end
        for (int c = 0; c < C; c++) if (cv[c]) ref_free[ct[c*TW +: TW]] = 1;
        #1;
        n_tests++;
        if (in_stall !== exp_stall) begin
            n_fail++;
            $display("FAIL %s stall: actual %b expected %b", req, in_stall, exp_stall);
        end
        q_exp.push_back(e);
        q_req.push_back(req);
    endtask

    task automatic idle(input logic [C-1:0] cv, input logic [C*TW-1:0] ct, input string req);
        drive(0, 0, '0, '0, '0, '0, '0, cv, ct, req);
    endtask

    // monitor: compares one expected item per cycle after the result edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                item_t e;
                string r;
                bit bad;
                logic [W*TW-1:0] m;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                bad = (out_valid !== e.valid);
                if (e.valid && !bad) begin
                    m = '0;
                    for (int k = 0; k < W; k++) if (e.vld[k]) m[k*TW +: TW] = '1;
                    if (out_tid !== e.tid || out_slot_vld !== e.vld || out_dst_en !== e.den) bad = 1;
                    if ((out_src_a_tag & m) !== (e.sa & m)) bad = 1;
                    if ((out_src_b_tag & m) !== (e.sb & m)) bad = 1;
                    m = '0;
                    for (int k = 0; k < W; k++) if (e.den[k]) m[k*TW +: TW] = '1;
                    if ((out_dst_tag & m) !== (e.dt & m)) bad = 1;
                    if ((out_old_tag & m) !== (e.ot & m)) bad = 1;
                end
                n_tests++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: actual v=%b sa=%h sb=%h dt=%h ot=%h expected v=%b sa=%h sb=%h dt=%h ot=%h",
                             r, out_valid, out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag,
                             e.valid, e.sa, e.sb, e.dt, e.ot);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < T; t++) for (int i = 0; i < A; i++) ref_map[t][i] = t*A + i;
        for (int i = 0; i < P; i++) ref_free[i] = (i >= T*A);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R8 reset state, R1 reset mapping of both threads
        idle('0, '0, "R8_reset");
        drive(1, 0, 4'hF, 4'h0, '0, pk(0,1,2,3), pk(4,5,6,7), '0, '0, "R1_t0");
        drive(1, 1, 4'hF, 4'h0, '0, pk(0,1,2,3), pk(4,5,6,7), '0, '0, "R1_t1");
        // R3 lowest tags in slot order, R5 old mapping
        drive(1, 0, 4'hF, 4'hF, pk(1,2,3,4), pk(1,2,3,4), pk(0,0,0,0), '0, '0, "R3_R5");
        // R4 forwarding inside a group, R5 old from earlier slot
        drive(1, 0, 4'h7, 4'h7, pk(5,5,6,0), pk(0,5,5,0), pk(0,0,1,0), '0, '0, "R4_R5_fwd");
        // R2 other thread untouched
        drive(1, 1, 4'hF, 4'h0, '0, pk(1,2,3,4), pk(5,6,0,7), '0, '0, "R2_iso");
        drive(1, 1, 4'hF, 4'hF, pk(0,1,2,3), pk(4,4,4,4), pk(0,1,2,3), '0, '0, "R3_t1");
        drive(1, 0, 4'hF, 4'hF, pk(0,1,2,3), pk(5,6,7,0), pk(1,2,3,4), '0, '0, "R3_t0");
        // R6 stall: one free tag, two needed
        drive(1, 1, 4'h3, 4'h3, pk(4,5,0,0), pk(0,0,0,0), pk(0,0,0,0), '0, '0, "R6_stall");
        drive(1, 1, 4'h3, 4'h1, pk(0,0,0,0), pk(1,0,0,0), pk(0,0,0,0), '0, '0, "R6_after");
        // R7 release in the same cycle as a group on an empty pool
        drive(1, 0, 4'h1, 4'h1, pk(7,0,0,0), pk(7,0,0,0), pk(0,0,0,0), 2'b11, pc(1,2), "R7_same");
        // R9 thread 1 receives tags freed by thread 0's commit
        drive(1, 1, 4'h1, 4'h1, pk(6,0,0,0), pk(6,0,0,0), pk(0,0,0,0), '0, '0, "R9_share");
        drive(1, 0, 4'h1, 4'h1, pk(7,0,0,0), pk(7,0,0,0), pk(0,0,0,0), '0, '0, "R9_next");
        idle(2'b11, pc(16,17), "R7_release");
        // R6 partially covered group with release in flight, then R8 mixed slots
        drive(1, 0, 4'hF, 4'hF, pk(1,2,3,4), pk(0,0,0,0), pk(0,0,0,0), 2'b01, pc(3,0), "R6_R7");
        drive(1, 0, 4'hF, 4'h9, pk(6,0,0,6), pk(6,6,6,6), pk(1,2,3,4), '0, '0, "R8_mix");
        idle('0, '0, "R8_idle");
        idle('0, '0, "R8_idle2");
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule